// File: doc/BRIEF.md
# Agent-Gated Key Register Bank

This block stores a 128-bit secret key as four 32-bit words. It guards the key with two per-agent permission bitmaps: one for reading and one for writing. Every bus access carries the identity of the requesting agent. A read of a key word is allowed only if the read bitmap has that agent's bit set. A write is allowed only if the write bitmap has that agent's bit set. Because the two bitmaps are separate, one agent can be allowed to read the key but not change it, and another can be allowed to change it but not read it back.

Both bitmaps sit on the same bus as the key. Only the boot agent (identity 2) may change them, and any agent may read them. After reset, both bitmaps admit only the boot agent. Boot firmware then narrows them. A typical setup lets only agent 1 (the crypto user) read the key and only agent 2 write it.

The controller is a small state machine, and each state records the outcome of the previous access:
- `S_IDLE`: no access was made.
- `S_RD_DONE`: a granted read; its data is on the bus.
- `S_WR_DONE`: a granted write.
- `S_REJECT`: a denied, malformed or unmapped access; the error flag is raised.

From any state, the next state is chosen by the current strobes, the decoded region and the permission bits:
- No strobe leads to `S_IDLE`.
- A granted read leads to `S_RD_DONE`.
- A granted write leads to `S_WR_DONE`.
- Anything else leads to `S_REJECT`.

Top module: `keyvault_acl`

## Requirements
- R1: After reset, all key words are zero. Both the read and write bitmaps read 0x0000_0004, meaning only agent 2 is admitted. `bus_rdata` and `bus_err` are zero.
- R2: The address map uses byte offsets. Key words 0 to 3 sit at 0x00, 0x04, 0x08 and 0x0C. The read bitmap is at 0x10 and the write bitmap is at 0x14. Bit n of a bitmap belongs to agent n, and a 1 grants access.
- R3: A key read by an agent whose read bit is 1 returns the stored word on `bus_rdata`, with `bus_err` low, in the cycle after the strobe.
- R4: A key read by an agent whose read bit is 0 returns all zeros with `bus_err` high in the cycle after the strobe.
- R5: A key write by an agent whose write bit is 1 updates the word at that clock edge. A read issued on the next cycle returns the new value.
- R6: A key write by an agent whose write bit is 0 leaves the key unchanged and raises `bus_err` in the next cycle.
- R7: Only agent 2 may write a bitmap; a write from any other agent is rejected with `bus_err` and leaves the bitmap unchanged. Any agent may read either bitmap without error.
- R8: A misaligned address (low two bits not zero) or an offset above 0x14 returns zeros with `bus_err` high and changes no state.
- R9: If `bus_rd` and `bus_wr` are both high in the same cycle, the access is rejected with `bus_err` and nothing is written.
- R10: Read and write permission are independent. With the read bitmap set to 0x2 and the write bitmap set to 0x4, agent 1 can read but not write, and agent 2 can write but not read. Agent 31 is governed by bit 31.
- R11: The response lasts exactly one cycle. In a cycle with no strobe, the next cycle shows `bus_err` low and `bus_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_agent | input | 5 | Identity of the requesting agent |
| bus_addr | input | 8 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a granted read, zero otherwise |
| bus_err | output | 1 | Rejection flag for the access of the previous cycle |

## Verification
If the controller lands in a wrong state, the fault shows on `bus_err` or `bus_rdata` exactly one cycle after the strobe. A granted read that lands in `S_REJECT` returns zero with the error flag. A denied read that lands in `S_RD_DONE` exposes key bits. A wrong write enable or bitmap bit stays hidden until a later read of that key word or bitmap. For that reason the stimulus reads back every word it writes, and reads both bitmaps after each rejected change.

// File: rtl/keyvault_pkg.sv
`timescale 1ns/1ps
package keyvault_pkg;
    typedef enum logic [1:0] {
        REG_KEY,
        REG_RPOL,
        REG_WPOL,
        REG_NONE
    } kv_region_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_DONE,
        S_WR_DONE,
        S_REJECT
    } kv_state_e;
endpackage

// File: rtl/kv_decode.sv
`timescale 1ns/1ps
module kv_decode
    import keyvault_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int KEY_WORDS = 4,
    parameter int IDX_W     = $clog2(KEY_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output kv_region_e        region,
    output logic [IDX_W-1:0]  idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    always_comb begin
        word   = addr[ADDR_W-1:2];
        idx    = word[IDX_W-1:0];
        region = REG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (int'(word) < KEY_WORDS) begin
                region = REG_KEY;
            end else if (int'(word) == KEY_WORDS) begin
                region = REG_RPOL;
            end else if (int'(word) == KEY_WORDS + 1) begin
                region = REG_WPOL;
            end
        end
    end
endmodule

// File: rtl/kv_policy.sv
`timescale 1ns/1ps
module kv_policy #(
    parameter int AGENTS     = 32,
    parameter int AGENT_W    = $clog2(AGENTS),
    parameter int DATA_W     = 32,
    parameter int BOOT_AGENT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AGENT_W-1:0] agent,
    input  logic               rpol_we,
    input  logic               wpol_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [AGENTS-1:0]  rpol,
    output logic [AGENTS-1:0]  wpol,
    output logic               rd_ok,
    output logic               wr_ok,
    output logic               boot_ok
);
    localparam logic [AGENTS-1:0] POL_RST = AGENTS'(1) << BOOT_AGENT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpol <= POL_RST;
            wpol <= POL_RST;
        end else begin
            if (rpol_we) rpol <= wdata[AGENTS-1:0];
            if (wpol_we) wpol <= wdata[AGENTS-1:0];
        end
    end

    assign rd_ok   = rpol[agent];
    assign wr_ok   = wpol[agent];
    assign boot_ok = (agent == AGENT_W'(BOOT_AGENT));
endmodule

// File: rtl/kv_keystore.sv
`timescale 1ns/1ps
module kv_keystore #(
    parameter int KEY_WORDS = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = $clog2(KEY_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rword,
    output logic [KEY_WORDS*DATA_W-1:0]   key_flat
);
    logic [DATA_W-1:0] words [KEY_WORDS];

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                words[g] <= wdata;
            end
        end
        assign key_flat[g*DATA_W +: DATA_W] = words[g];
    end

    assign rword = words[idx];
endmodule

// File: rtl/keyvault_acl.sv
`timescale 1ns/1ps
module keyvault_acl
    import keyvault_pkg::*;
#(
    parameter int AGENTS     = 32,
    parameter int AGENT_W    = $clog2(AGENTS),
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int KEY_WORDS  = 4,
    parameter int BOOT_AGENT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AGENT_W-1:0] bus_agent,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err
);
    localparam int IDX_W = $clog2(KEY_WORDS);

    kv_region_e              region;
    logic [IDX_W-1:0]        idx;
    logic                    key_we, rpol_we, wpol_we;
    logic [AGENTS-1:0]       rpol_q, wpol_q;
    logic                    rd_ok, wr_ok, boot_ok;
    logic [DATA_W-1:0]       rword;
    logic [KEY_WORDS*DATA_W-1:0] key_flat;

    kv_state_e               state, nxt;
    logic [DATA_W-1:0]       data_q, nxt_data;

    kv_decode #(.ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS), .IDX_W(IDX_W)) u_decode (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    kv_policy #(.AGENTS(AGENTS), .AGENT_W(AGENT_W), .DATA_W(DATA_W),
                .BOOT_AGENT(BOOT_AGENT)) u_policy (
        .clk     (clk),
        .rst_n   (rst_n),
        .agent   (bus_agent),
        .rpol_we (rpol_we),
        .wpol_we (wpol_we),
        .wdata   (bus_wdata),
        .rpol    (rpol_q),
        .wpol    (wpol_q),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok),
        .boot_ok (boot_ok)
    );

    kv_keystore #(.KEY_WORDS(KEY_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (key_we),
        .idx      (idx),
        .wdata    (bus_wdata),
        .rword    (rword),
        .key_flat (key_flat)
    );

    // Decision: classify the current access and raise the matching write enable.
    always_comb begin
        nxt      = S_IDLE;
        nxt_data = '0;
        key_we   = 1'b0;
        rpol_we  = 1'b0;
        wpol_we  = 1'b0;
        if (bus_rd && bus_wr) begin
            nxt = S_REJECT;
        end else if (bus_rd) begin
            unique case (region)
                REG_KEY: begin
                    if (rd_ok) begin
                        nxt      = S_RD_DONE;
                        nxt_data = rword;
                    end else begin
                        nxt = S_REJECT;
                    end
                end
                REG_RPOL: begin
                    nxt      = S_RD_DONE;
                    nxt_data = DATA_W'(rpol_q);
                end
                REG_WPOL: begin
                    nxt      = S_RD_DONE;
                    nxt_data = DATA_W'(wpol_q);
                end
                REG_NONE: nxt = S_REJECT;
            endcase
        end else if (bus_wr) begin
            unique case (region)
                REG_KEY: begin
                    if (wr_ok) begin
                        nxt    = S_WR_DONE;
                        key_we = 1'b1;
                    end else begin
                        nxt = S_REJECT;
                    end
                end
                REG_RPOL: begin
                    if (boot_ok) begin
                        nxt     = S_WR_DONE;
                        rpol_we = 1'b1;
                    end else begin
                        nxt = S_REJECT;
                    end
                end
                REG_WPOL: begin
                    if (boot_ok) begin
                        nxt     = S_WR_DONE;
                        wpol_we = 1'b1;
                    end else begin
                        nxt = S_REJECT;
                    end
                end
                REG_NONE: nxt = S_REJECT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            data_q <= '0;
        end else begin
            state  <= nxt;
            data_q <= nxt_data;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        bus_rdata = '0;
        bus_err   = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_RD_DONE: bus_rdata = data_q;
            S_WR_DONE: ;
            S_REJECT:  bus_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/kv_acl_checker.sv
`timescale 1ns/1ps
module kv_acl_checker
    import keyvault_pkg::*;
#(
    parameter int AGENTS     = 32,
    parameter int AGENT_W    = $clog2(AGENTS),
    parameter int DATA_W     = 32,
    parameter int KEY_WORDS  = 4,
    parameter int BOOT_AGENT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AGENT_W-1:0]          bus_agent,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_rdata,
    input  logic                        bus_err,
    input  kv_region_e                  region,
    input  logic [AGENTS-1:0]           rpol_q,
    input  logic [AGENTS-1:0]           wpol_q,
    input  logic [KEY_WORDS*DATA_W-1:0] key_flat
);
    p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    p_deny_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && region == REG_KEY && !rpol_q[bus_agent]) |=> bus_err);

    p_key_guarded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_rd && region == REG_KEY && wpol_q[bus_agent])
        |=> $stable(key_flat));

    p_policy_boot_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_agent != AGENT_W'(BOOT_AGENT)) |=> ($stable(rpol_q) && $stable(wpol_q)));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && region == REG_NONE) |=> bus_err);

    p_both_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> (bus_err && $stable(key_flat)));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> (!bus_err && bus_rdata == '0));
endmodule

bind keyvault_acl kv_acl_checker #(
    .AGENTS(AGENTS), .AGENT_W(AGENT_W), .DATA_W(DATA_W),
    .KEY_WORDS(KEY_WORDS), .BOOT_AGENT(BOOT_AGENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_agent (bus_agent),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .region    (region),
    .rpol_q    (rpol_q),
    .wpol_q    (wpol_q),
    .key_flat  (key_flat)
);

// File: tb/keyvault_acl_bench.sv
`timescale 1ns/1ps
module keyvault_acl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_agent = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    keyvault_acl u_keyvault_acl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_agent (bus_agent),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    typedef struct packed {
        logic [4:0]  agent;
        logic [7:0]  addr;
        logic        rd;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] exp_data;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{5'd2, 8'h00, 1'b1, 1'b0, 32'h0,         32'h0,         1'b0, 4'd1},  // R1 key zero
        '{5'd2, 8'h00, 1'b0, 1'b1, 32'hA5A5_0001, 32'h0,         1'b0, 4'd5},  // R5
        '{5'd2, 8'h0C, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0,         1'b0, 4'd5},  // R5 / R2 word 3
        '{5'd2, 8'h00, 1'b1, 1'b0, 32'h0,         32'hA5A5_0001, 1'b0, 4'd3},  // R3
        '{5'd2, 8'h10, 1'b1, 1'b0, 32'h0,         32'h0000_0004, 1'b0, 4'd1},  // R1 read bitmap
        '{5'd1, 8'h14, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0,         1'b1, 4'd7},  // R7 non-boot
        '{5'd2, 8'h10, 1'b0, 1'b1, 32'h0000_0002, 32'h0,         1'b0, 4'd7},  // R7 boot writes
        '{5'd2, 8'h00, 1'b1, 1'b0, 32'h0,         32'h0,         1'b1, 4'd4},  // R4 / R10
        '{5'd1, 8'h0C, 1'b1, 1'b0, 32'h0,         32'hDEAD_BEEF, 1'b0, 4'd10}, // R10
        '{5'd1, 8'h04, 1'b0, 1'b1, 32'h0000_1111, 32'h0,         1'b1, 4'd6},  // R6 / R10
        '{5'd1, 8'h04, 1'b1, 1'b0, 32'h0,         32'h0,         1'b0, 4'd6},  // R6 unchanged
        '{5'd2, 8'h04, 1'b0, 1'b1, 32'h2222_3333, 32'h0,         1'b0, 4'd5},  // R5
        '{5'd1, 8'h04, 1'b1, 1'b0, 32'h0,         32'h2222_3333, 1'b0, 4'd5},  // R5
        '{5'd1, 8'h18, 1'b1, 1'b0, 32'h0,         32'h0,         1'b1, 4'd8},  // R8 above map
        '{5'd1, 8'h02, 1'b1, 1'b0, 32'h0,         32'h0,         1'b1, 4'd8},  // R8 misaligned
        '{5'd2, 8'h00, 1'b1, 1'b1, 32'h0BAD_0BAD, 32'h0,         1'b1, 4'd9},  // R9
        '{5'd1, 8'h00, 1'b1, 1'b0, 32'h0,         32'hA5A5_0001, 1'b0, 4'd9},  // R9 unchanged
        '{5'd5, 8'h10, 1'b1, 1'b0, 32'h0,         32'h0000_0002, 1'b0, 4'd7},  // R7 any reader
        '{5'd2, 8'h15, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0,         1'b1, 4'd8},  // R8 misaligned write
        '{5'd9, 8'h14, 1'b1, 1'b0, 32'h0,         32'h0000_0004, 1'b0, 4'd8}   // R8 no change, R2
    };

    task automatic compare(input logic [31:0] exp_d, input logic exp_e, input string tag);
        checks++;
        if (bus_rdata !== exp_d || bus_err !== exp_e) begin
            fails++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     tag, bus_rdata, bus_err, exp_d, exp_e);
        end
    endtask

    // Called at a falling edge; drives one access, checks the response one edge later.
    task automatic access(input logic [4:0] ag, input logic [7:0] ad, input logic r,
                          input logic w, input logic [31:0] wd, input logic [31:0] exp_d,
                          input logic exp_e, input string tag);
        bus_agent = ag; bus_addr = ad; bus_rd = r; bus_wr = w; bus_wdata = wd;
        @(negedge clk);
        compare(exp_d, exp_e, tag);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare(32'h0, 1'b0, "R1 outputs after reset");

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].agent, VECS[i].addr, VECS[i].rd, VECS[i].wr, VECS[i].wdata,
                   VECS[i].exp_data, VECS[i].exp_err, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R11: error lasts one cycle; quiet cycle follows a rejection.
        access(5'd3, 8'h00, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, "R11 denied read");
        @(negedge clk);
        compare(32'h0, 1'b0, "R11 quiet after rejection");

        // R10: agent 31 is governed by bit 31 of the write bitmap.
        access(5'd31, 8'h08, 1'b0, 1'b1, 32'h3131_3131, 32'h0, 1'b1, "R10 agent31 write denied");
        access(5'd2,  8'h14, 1'b0, 1'b1, 32'h8000_0004, 32'h0, 1'b0, "R10 boot opens bit31");
        access(5'd31, 8'h08, 1'b0, 1'b1, 32'h3131_3131, 32'h0, 1'b0, "R10 agent31 write granted");
        access(5'd1,  8'h08, 1'b1, 1'b0, 32'h0, 32'h3131_3131, 1'b0, "R10 agent1 reads word2");
        access(5'd31, 8'h08, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, "R10 agent31 read denied");

        // R1: reset mid-run restores defaults.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        compare(32'h0, 1'b0, "R1 outputs after second reset");
        access(5'd2, 8'h08, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, "R1 key cleared");
        access(5'd2, 8'h14, 1'b1, 1'b0, 32'h0, 32'h0000_0004, 1'b0, "R1 write bitmap default");
        access(5'd1, 8'h0C, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, "R1 agent1 not admitted");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule